// File: doc/BRIEF.md
# Cascadable FIFO Depth-Expansion Controller

This block joins several identical FIFO slices into one deeper FIFO. Each slice has its own storage, a write pointer, a read pointer and an occupancy counter. A slice accepts writes only while it owns the write token, and reads only while it owns the read token. When the owning slice writes its last location, it passes the write token to the next slice in the ring. When the owning slice reads its last location, it passes the read token the same way. The hand-off is a one-cycle active-low expansion pulse, qualified as a write hand-off, a read hand-off or both. The last slice's expansion output feeds the first slice's expansion input, so ownership goes round the ring without end.

The slice whose first-load strap is low starts out owning both tokens. The chain top ties that strap low on slice 0 and high on every other slice. The composite empty flag and the composite full flag are active low. Each one is low only when the matching flag of every slice is low.

If slice 0 sees its expansion input held low during reset, it latches single-slice mode. In that mode it works as a plain FIFO of `DEPTH` words and drives its expansion output as an active-low half-full flag. The strap is sampled only while reset is asserted. Reset is synchronous and active high, and it must be held for at least two clock cycles.

Top module: `fifo_xp_chain`

## Requirements
- R1: While reset is high and on the first cycle after it falls, the outputs are `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_vld`=0, and every slice starts at location zero.
- R2: Words leave in the order they were written, across slice boundaries. The chain capacity is `NDEV*DEPTH` words.
- R3: When the chain holds `NDEV*DEPTH` words, `full_n` is 0 and writes are dropped. `empty_n` and `full_n` are never 0 together.
- R4: When the chain is empty, `empty_n` is 0, reads are dropped, and `dout_vld` stays 0 with `dout` equal to 0.
- R5: A slice that writes its last location pulses its expansion output for one cycle with the write qualifier set. On the next cycle the following slice owns the write token, so no cycle is lost at the boundary.
- R6: In chained mode exactly one slice owns the write token and exactly one slice owns the read token at any time.
- R7: Ownership returns from the last slice to slice 0, so streaming continues past any number of passes round the ring.
- R8: A read accepted at a clock edge puts its word on `dout`, with `dout_vld`=1, right after that edge and for one cycle.
- R9: `solo_strap`=1 during reset selects single-slice mode, with a capacity of `DEPTH` words. Changing `solo_strap` after reset has no effect on the mode.
- R10: In single-slice mode, `half_n` is 0 exactly when occupancy exceeds `DEPTH/2`. In chained mode `half_n` stays 1.
- R11: A read and a write in the same cycle both take effect when the chain is neither empty nor full. Occupancy then stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| solo_strap | input | 1 | High during reset selects single-slice mode |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe, one word per cycle |
| din | input | W | Write data |
| dout | output | W | Read data, zero when not valid |
| dout_vld | output | 1 | High for one cycle after an accepted read |
| empty_n | output | 1 | Composite empty flag, active low |
| full_n | output | 1 | Composite full flag, active low |
| half_n | output | 1 | Half-full flag in single-slice mode, active low |

## Verification
A lost or duplicated token shows up at the slice boundary. A second owner makes a word appear twice or out of order. A lost token makes writes or reads stall, so the flags stick, usually within `DEPTH` operations of the fault. A wrong occupancy count in one slice shows up as a wrong composite flag or a false `dout_vld` once that slice's turn comes round. A mode latch that follows the strap after reset changes the capacity or the half-full output on the next write.

// File: rtl/fifo_xp_pkg.sv
package fifo_xp_pkg;
  // Expansion link between neighbouring slices: active-low pulse plus
  // qualifiers naming which token is handed over.
  typedef struct packed {
    logic pulse_n;
    logic wr;
    logic rd;
  } xp_link_t;

  localparam xp_link_t LINK_IDLE   = '{pulse_n: 1'b1, wr: 1'b0, rd: 1'b0};
  localparam xp_link_t LINK_GROUND = '{pulse_n: 1'b0, wr: 1'b0, rd: 1'b0};
endpackage

// File: rtl/fifo_xp_ram.sv
module fifo_xp_ram #(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_xp_node.sv
module fifo_xp_node
  import fifo_xp_pkg::*;
#(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     first_load_n,
  input  xp_link_t link_in,
  output xp_link_t link_out,
  input  logic     wr_en,
  input  logic     rd_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic     q_vld,
  output logic     empty_n,
  output logic     full_n,
  output logic     wr_owner,
  output logic     rd_owner,
  output logic     solo_mode
);
  logic          solo_q, wtok, rtok, vld_q;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nx;
  logic [W-1:0]  ram_q;
  logic          take_w, take_r, do_wr, do_rd, last_w, last_r, pass_w, pass_r;

  // A hand-off pulse grants ownership in the same cycle it is seen.
  assign take_w   = !solo_q && !link_in.pulse_n && link_in.wr;
  assign take_r   = !solo_q && !link_in.pulse_n && link_in.rd;
  assign wr_owner = solo_q || wtok || take_w;
  assign rd_owner = solo_q || rtok || take_r;

  assign do_wr  = wr_en && wr_owner && (cnt != CW'(DEPTH));
  assign do_rd  = rd_en && rd_owner && (cnt != '0);
  assign last_w = (wptr == AW'(DEPTH - 1));
  assign last_r = (rptr == AW'(DEPTH - 1));
  assign pass_w = !solo_q && do_wr && last_w;
  assign pass_r = !solo_q && do_rd && last_r;
  assign cnt_nx = cnt + CW'(do_wr) - CW'(do_rd);

  fifo_xp_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (do_wr),
    .waddr (wptr),
    .wdata (din),
    .re    (do_rd),
    .raddr (rptr),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      solo_q   <= !link_in.pulse_n;
      wtok     <= !first_load_n;
      rtok     <= !first_load_n;
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      empty_n  <= 1'b0;
      full_n   <= 1'b1;
      vld_q    <= 1'b0;
      link_out <= LINK_IDLE;
    end else begin
      wtok    <= (wtok || take_w) && !pass_w;
      rtok    <= (rtok || take_r) && !pass_r;
      if (do_wr) wptr <= last_w ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= last_r ? '0 : rptr + 1'b1;
      cnt     <= cnt_nx;
      empty_n <= (cnt_nx != '0);
      full_n  <= (cnt_nx != CW'(DEPTH));
      vld_q   <= do_rd;
      if (solo_q) begin
        link_out.pulse_n <= !(cnt_nx > CW'(HALF));
        link_out.wr      <= 1'b0;
        link_out.rd      <= 1'b0;
      end else begin
        link_out.pulse_n <= !(pass_w || pass_r);
        link_out.wr      <= pass_w;
        link_out.rd      <= pass_r;
      end
    end
  end

  assign q         = ram_q & {W{vld_q}};
  assign q_vld     = vld_q;
  assign solo_mode = solo_q;
endmodule

// File: rtl/fifo_xp_merge.sv
module fifo_xp_merge #(
  parameter int W    = 9,
  parameter int NDEV = 3
) (
  input  logic [NDEV-1:0]        empty_n_v,
  input  logic [NDEV-1:0]        full_n_v,
  input  logic [NDEV-1:0]        vld_v,
  input  logic [NDEV-1:0][W-1:0] q_v,
  input  logic                   solo,
  input  logic                   hf0_n,
  output logic [W-1:0]           dout,
  output logic                   dout_vld,
  output logic                   empty_n,
  output logic                   full_n,
  output logic                   half_n
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < NDEV; i++) dout = dout | q_v[i];
  end

  assign dout_vld = |vld_v;
  assign empty_n  = |empty_n_v;
  assign full_n   = solo ? full_n_v[0] : |full_n_v;
  assign half_n   = solo ? hf0_n : 1'b1;
endmodule

// File: rtl/fifo_xp_chain.sv
module fifo_xp_chain
  import fifo_xp_pkg::*;
#(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  parameter int NDEV  = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         solo_strap,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_vld,
  output logic         empty_n,
  output logic         full_n,
  output logic         half_n
);
  xp_link_t lnk_out [NDEV];
  xp_link_t lnk_in  [NDEV];
  logic [NDEV-1:0]        empty_n_v, full_n_v, vld_v, own_w_v, own_r_v, mode_v;
  logic [NDEV-1:0]        lnk_pn_v, lnk_wr_v, lnk_rd_v;
  logic [NDEV-1:0][W-1:0] q_v;
  logic                   ground0;

  // Slice 0's expansion input is grounded by the strap during reset and by
  // the latched mode afterwards, so a late strap change cannot break the ring.
  assign ground0 = rst ? solo_strap : mode_v[0];

  for (genvar i = 0; i < NDEV; i++) begin : g_slice
    if (i == 0) begin : g_head
      assign lnk_in[i] = ground0 ? LINK_GROUND : lnk_out[NDEV-1];
    end else begin : g_tail
      assign lnk_in[i] = lnk_out[i-1];
    end

    fifo_xp_node #(.W(W), .DEPTH(DEPTH)) u_node (
      .clk          (clk),
      .rst          (rst),
      .first_load_n (i != 0),
      .link_in      (lnk_in[i]),
      .link_out     (lnk_out[i]),
      .wr_en        (wr_en),
      .rd_en        (rd_en),
      .din          (din),
      .q            (q_v[i]),
      .q_vld        (vld_v[i]),
      .empty_n      (empty_n_v[i]),
      .full_n       (full_n_v[i]),
      .wr_owner     (own_w_v[i]),
      .rd_owner     (own_r_v[i]),
      .solo_mode    (mode_v[i])
    );

    assign lnk_pn_v[i] = lnk_out[i].pulse_n;
    assign lnk_wr_v[i] = lnk_out[i].wr;
    assign lnk_rd_v[i] = lnk_out[i].rd;
  end

  fifo_xp_merge #(.W(W), .NDEV(NDEV)) u_merge (
    .empty_n_v (empty_n_v),
    .full_n_v  (full_n_v),
    .vld_v     (vld_v),
    .q_v       (q_v),
    .solo      (mode_v[0]),
    .hf0_n     (lnk_out[0].pulse_n),
    .dout      (dout),
    .dout_vld  (dout_vld),
    .empty_n   (empty_n),
    .full_n    (full_n),
    .half_n    (half_n)
  );
endmodule

// File: rtl/fifo_xp_chain_chk.sv
module fifo_xp_chain_chk #(
  parameter int NDEV = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            empty_n,
  input logic            full_n,
  input logic            half_n,
  input logic            dout_vld,
  input logic            mode0,
  input logic [NDEV-1:0] own_w_v,
  input logic [NDEV-1:0] own_r_v,
  input logic [NDEV-1:0] lnk_wr_v,
  input logic [NDEV-1:0] lnk_rd_v
);
  // R1: first cycle out of reset shows the reset flag values
  a_r1_reset_flags: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!empty_n && full_n && half_n && !dout_vld));

  // R3: empty and full never asserted together
  a_r3_not_both: assert property (@(posedge clk) disable iff (rst)
    !(!empty_n && !full_n));

  // R4: a read against an empty chain yields no data
  a_r4_empty_no_data: assert property (@(posedge clk) disable iff (rst)
    !empty_n |=> !dout_vld);

  // R6: one write owner and one read owner in chained mode
  a_r6_one_writer: assert property (@(posedge clk) disable iff (rst)
    !mode0 |-> $onehot(own_w_v));
  a_r6_one_reader: assert property (@(posedge clk) disable iff (rst)
    !mode0 |-> $onehot(own_r_v));

  // R9: latched mode does not follow the strap after reset
  a_r9_mode_stable: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode0));

  // R10: half-full unavailable when chained
  a_r10_half_chain: assert property (@(posedge clk) disable iff (rst)
    !mode0 |-> half_n);

  for (genvar i = 0; i < NDEV; i++) begin : g_link
    // R5: a write hand-off makes the next slice the write owner, and does not repeat
    a_r5_wr_handoff: assert property (@(posedge clk) disable iff (rst)
      (!mode0 && lnk_wr_v[i]) |-> own_w_v[(i + 1) % NDEV]);
    a_r5_wr_once: assert property (@(posedge clk) disable iff (rst)
      lnk_wr_v[i] |=> !lnk_wr_v[i]);
    // R7: read hand-off from the last slice lands on slice 0 like any other
    a_r7_rd_handoff: assert property (@(posedge clk) disable iff (rst)
      (!mode0 && lnk_rd_v[i]) |-> own_r_v[(i + 1) % NDEV]);
  end
endmodule

bind fifo_xp_chain fifo_xp_chain_chk #(.NDEV(NDEV)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .empty_n  (empty_n),
  .full_n   (full_n),
  .half_n   (half_n),
  .dout_vld (dout_vld),
  .mode0    (mode_v[0]),
  .own_w_v  (own_w_v),
  .own_r_v  (own_r_v),
  .lnk_wr_v (lnk_wr_v),
  .lnk_rd_v (lnk_rd_v)
);

// File: tb/sim_fifo_xp_chain.sv
module sim_fifo_xp_chain;
  localparam int W     = 9;
  localparam int DEPTH = 4;
  localparam int NDEV  = 3;
  localparam int CAP   = DEPTH * NDEV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic solo_strap = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic dout_vld, empty_n, full_n, half_n;

  int errors = 0, checks = 0;
  int model[$];
  bit solo_m = 1'b0;
  int nxt = 1;

  always #5 clk = ~clk;

  fifo_xp_chain #(.W(W), .DEPTH(DEPTH), .NDEV(NDEV)) u0 (
    .clk(clk), .rst(rst), .solo_strap(solo_strap), .wr_en(wr_en), .rd_en(rd_en),
    .din(din), .dout(dout), .dout_vld(dout_vld), .empty_n(empty_n),
    .full_n(full_n), .half_n(half_n)
  );

  // {wr, rd, repeat count, expected occupancy after the segment}
  localparam int NVEC = 15;
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 6'd5,  5'd5},
    {1'b0, 1'b1, 6'd2,  5'd3},
    {1'b1, 1'b1, 6'd6,  5'd3},
    {1'b1, 1'b0, 6'd9,  5'd12},
    {1'b1, 1'b0, 6'd3,  5'd12},
    {1'b1, 1'b1, 6'd2,  5'd11},
    {1'b0, 1'b1, 6'd11, 5'd0},
    {1'b0, 1'b1, 6'd2,  5'd0},
    {1'b1, 1'b1, 6'd1,  5'd1},
    {1'b1, 1'b0, 6'd11, 5'd12},
    {1'b0, 1'b1, 6'd12, 5'd0},
    {1'b1, 1'b0, 6'd7,  5'd7},
    {1'b0, 1'b1, 6'd3,  5'd4},
    {1'b1, 1'b1, 6'd10, 5'd4},
    {1'b0, 1'b1, 6'd4,  5'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst = 1'b1; solo_strap = s; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model.delete();
    solo_m = s;
    chk("R1 reset flags", {31'd0, empty_n}, 32'd0);
    chk("R1 reset full", {31'd0, full_n}, 32'd1);
    chk("R1 reset half", {31'd0, half_n}, 32'd1);
    chk("R1 reset vld", {31'd0, dout_vld}, 32'd0);
  endtask

  // One cycle: drive at negedge, sample at the following negedge.
  task automatic step(input bit w, input bit r, input string tag);
    int cap_now;
    bit acc_w, acc_r;
    int exp_d;
    cap_now = solo_m ? DEPTH : CAP;
    wr_en = w; rd_en = r; din = W'(nxt);
    acc_w = w && (model.size() < cap_now);
    acc_r = r && (model.size() > 0);
    exp_d = acc_r ? model[0] : 0;
    @(posedge clk);
    if (acc_r) void'(model.pop_front());
    if (acc_w) begin model.push_back(nxt); nxt = (nxt + 1) % (1 << W); end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk({tag, " data"}, {22'd0, dout_vld, dout}, {22'd0, acc_r, W'(exp_d)});
    chk({tag, " flags"}, {29'd0, empty_n, full_n, half_n},
        {29'd0, model.size() != 0, model.size() != cap_now,
         !(solo_m && model.size() > DEPTH / 2)});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    do_reset(1'b0);

    // R5: consecutive writes across the first boundary, no lost cycle
    for (int i = 0; i < DEPTH + 1; i++) step(1'b1, 1'b0, "R5 boundary write");
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 1'b1, "R5 boundary read");

    // R6: one word written, second read finds nothing
    do_reset(1'b0);
    step(1'b1, 1'b0, "R6 single write");
    step(1'b0, 1'b1, "R6 single read");
    step(1'b0, 1'b1, "R6 no duplicate");

    // Table walk: order R2, full R3, empty R4, wrap R7, latency R8, both R11
    do_reset(1'b0);
    for (int v = 0; v < NVEC; v++) begin
      for (int k = 0; k < int'(VEC[v][10:5]); k++)
        step(VEC[v][12], VEC[v][11], "R2 R3 R4 R7 R8 R11 table");
      chk("R3 R4 segment flags", {30'd0, empty_n, full_n},
          {30'd0, VEC[v][4:0] != 5'd0, VEC[v][4:0] != 5'(CAP)});
    end

    // R9: strap raised after reset in chained mode leaves capacity at CAP, R10 half stays high
    solo_strap = 1'b1;
    for (int i = 0; i < CAP + 1; i++) step(1'b1, 1'b0, "R9 R10 chained strap late");
    for (int i = 0; i < CAP; i++) step(1'b0, 1'b1, "R9 chained drain");

    // R9/R10: single-slice mode, capacity DEPTH, half-full behaviour
    do_reset(1'b1);
    solo_strap = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b0, "R9 R10 solo fill");
    chk("R9 solo full", {31'd0, full_n}, 32'd0);
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, "R10 solo drain");
    step(1'b0, 1'b1, "R4 solo empty read");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule